// File: doc/BRIEF.md
# Prescaled Single-Channel PWM

This block generates one pulse-width modulated output from a reference clock, nominally 24 MHz. Software programs it through two 32-bit registers on a simple synchronous port: a control word and a period/duty word.

The control word holds a 4-bit prescaler code. The code picks a fixed, non-power-of-two divide ratio, or it bypasses the divider entirely. The divided tick advances a 16-bit period counter. The output is at its active level while the counter is below the duty count. The control word also holds a channel enable, a polarity select and a gate for the prescaled clock.

New period/duty values are taken into use only at a period boundary, so a running waveform never shows a cut-short pulse. To change the prescaler code, software must first drop the gate, then write the new code, then raise the gate again.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset both registers read zero, the channel is disabled and `pwm_o` is low.
- R2: Writing with `wr_en_i` high stores `wdata_i` in the control word (`addr_i`=0) or the period/duty word (`addr_i`=1). `rdata_o` returns all 32 bits of the register selected by `addr_i`, exactly as last written.
- R3: Control bits 3:0 select the number of reference cycles per counter step. The codes map as follows: 0 is 120, 1 is 180, 2 is 240, 3 is 360, 4 is 480, 8 is 12000, 9 is 24000, 10 is 36000, 11 is 48000, 12 is 72000, and 15 is 1 (bypass).
- R4: Codes 5, 6, 7, 13 and 14 are reserved. While one of them is selected, the counter holds its value and the output does not change.
- R5: While control bit 6 (clock gate) is low, the counter holds its value and the output stays frozen.
- R6: With the channel enabled, the output is active while the counter is below the duty count and inactive for the rest of the period. A duty count at or above the period count gives a constant active level. A duty count of zero gives a constant inactive level.
- R7: Control bit 5 set makes the active level low. Control bit 5 clear makes the active level high.
- R8: Control bit 4 enables the channel. While it is clear, the counter is held at zero and the output sits at the inactive level set by bit 5.
- R9: A period/duty write made while the channel runs takes effect only when the counter wraps at the end of the current period. While the channel is disabled, the written values are taken directly.
- R10: The period count sits in bits 31:16 and the duty count in bits 15:0 of the period/duty word. Each is a 16-bit count, up to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 period/duty |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| pwm_o | output | 1 | Modulated output |

## Verification
The assertions assume that software changes the prescaler code only while the clock gate is low. They also assume a period count of one or more whenever the counter-range property is meant to apply. The stimulus respects the gate rule by changing the code only with the gate low or the channel disabled. The stimulus chooses ratios of 1, 120 and 180 so that several full periods fit in a short run. The counter-hold properties rely on the tick staying low whenever the gate is low or a reserved code is selected. The bench drives exactly those cases to show the output frozen mid-period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PSC_W    = 17;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned EN_BIT   = 4;
  localparam int unsigned INV_BIT  = 5;
  localparam int unsigned GATE_BIT = 6;

  // zero marks a reserved code
  function automatic logic [PSC_W-1:0] psc_ratio(input logic [CODE_W-1:0] code);
    logic [PSC_W-1:0] r;
    case (code)
      4'd0:    r = PSC_W'(120);
      4'd1:    r = PSC_W'(180);
      4'd2:    r = PSC_W'(240);
      4'd3:    r = PSC_W'(360);
      4'd4:    r = PSC_W'(480);
      4'd8:    r = PSC_W'(12000);
      4'd9:    r = PSC_W'(24000);
      4'd10:   r = PSC_W'(36000);
      4'd11:   r = PSC_W'(48000);
      4'd12:   r = PSC_W'(72000);
      4'd15:   r = PSC_W'(1);
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] pd_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] ctrl_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pd_q   <= '0;
    end else if (wr_en_i) begin
      if (addr_i) pd_q   <= wdata_i;
      else        ctrl_q <= wdata_i;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign pd_o    = pd_q;
  assign rdata_o = addr_i ? pd_q : ctrl_q;

  a_r2_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> ctrl_q == $past(wdata_i));
  a_r2_pd_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i) |=> pd_q == $past(wdata_i));
  a_r2_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q) && $stable(pd_q));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              gate_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PSC_W-1:0] ratio, div_q;
  logic run;

  assign ratio  = psc_ratio(code_i);
  assign run    = en_i && gate_i && (ratio != '0);
  // >= keeps a shrunken ratio from running the divider through its full range
  assign tick_o = run && (div_q >= ratio - PSC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run)   div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + PSC_W'(1);
  end

  a_r4_reserved_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio == '0) |-> !tick_o);
  a_r5_gate_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |-> !tick_o);
  a_r3_bypass_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && gate_i && code_i == 4'hF) |-> tick_o);
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, prd_q, duty_q;
  logic wrap, active;

  assign wrap = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, prd_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prd_q  <= '0;
      duty_q <= '0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      prd_q  <= prd_i;
      duty_q <= duty_i;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        prd_q  <= prd_i;
        duty_q <= duty_i;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign active = cnt_q < duty_q;
  assign pwm_o  = en_i ? (active ^ inv_i) : inv_i;

  a_r8_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  a_r5_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
  a_r9_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(tick_i && wrap)) |=> $stable(prd_q) && $stable(duty_q));
  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_q != '0) |-> cnt_q < prd_q);
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        pwm_o
);
  logic [REG_W-1:0] ctrl, pd;
  logic tick;

  pwm_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ctrl_o (ctrl),
    .pd_o   (pd),
    .rdata_o
  );

  pwm_prescaler i_psc (
    .clk_i, .rst_ni,
    .en_i   (ctrl[EN_BIT]),
    .gate_i (ctrl[GATE_BIT]),
    .code_i (ctrl[CODE_W-1:0]),
    .tick_o (tick)
  );

  pwm_core i_core (
    .clk_i, .rst_ni,
    .en_i   (ctrl[EN_BIT]),
    .tick_i (tick),
    .inv_i  (ctrl[INV_BIT]),
    .prd_i  (pd[2*CNT_W-1:CNT_W]),
    .duty_i (pd[CNT_W-1:0]),
    .pwm_o
  );

  a_r8_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[EN_BIT] |-> pwm_o == ctrl[INV_BIT]);
endmodule

// File: tb/test_pwm_prescaled.sv
module test_pwm_prescaled;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  typedef struct { logic v; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  pwm_prescaled i_pwm_prescaled (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic int ref_ratio(input logic [3:0] c);
    case (c)
      4'd0: return 120;   4'd1: return 180;   4'd2: return 240;
      4'd3: return 360;   4'd4: return 480;   4'd8: return 12000;
      4'd9: return 24000; 4'd10: return 36000; 4'd11: return 48000;
      4'd12: return 72000; 4'd15: return 1;
      default: return 0;
    endcase
  endfunction

  // reference model, advanced once per rising edge
  logic [31:0] m_ctrl = '0, m_pd = '0;
  int m_pcnt = 0, m_cnt = 0, m_prd = 0, m_duty = 0;

  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      m_ctrl = '0; m_pd = '0; m_pcnt = 0; m_cnt = 0; m_prd = 0; m_duty = 0;
    end else begin
      int r;
      r = ref_ratio(m_ctrl[3:0]);
      if (!m_ctrl[4]) begin
        m_pcnt = 0; m_cnt = 0; m_prd = int'(m_pd[31:16]); m_duty = int'(m_pd[15:0]);
      end else if (!m_ctrl[6] || r == 0) begin
        m_pcnt = 0;
      end else if (m_pcnt >= r - 1) begin
        m_pcnt = 0;
        if (m_cnt + 1 >= m_prd) begin
          m_cnt = 0; m_prd = int'(m_pd[31:16]); m_duty = int'(m_pd[15:0]);
        end else m_cnt++;
      end else m_pcnt++;
      if (wr_en) begin
        if (addr) m_pd = wdata; else m_ctrl = wdata;
      end
    end
    e.v = m_ctrl[4] ? ((m_cnt < m_duty) ^ m_ctrl[5]) : m_ctrl[5];
    e.tag = cur_tag;
    q.push_back(e);
  end

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pwm !== e.v) begin
        errors++;
        $display("FAIL %s pwm_o actual %b expected %b at %0t", e.tag, pwm, e.v, $time);
      end
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata_o actual %h expected %h", tag, rdata, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_tag = "R1";
    rd_check(1'b0, 32'h0, "R1");
    rd_check(1'b1, 32'h0, "R1");
    run(2);
    // R2: exact readback, channel stays disabled (bits 6:4 clear)
    cur_tag = "R2";
    wr(1'b0, 32'hA5A5_0F80);
    wr(1'b1, 32'h1234_5678);
    rd_check(1'b0, 32'hA5A5_0F80, "R2");
    rd_check(1'b1, 32'h1234_5678, "R2");
    wr(1'b0, 32'h0);
    // R6 R10: period 5 duty 2, bypass code 15
    cur_tag = "R6";
    wr(1'b1, 32'h0005_0002);
    wr(1'b0, 32'h0000_005F);
    run(30);
    // R7: invert
    cur_tag = "R7";
    wr(1'b0, 32'h0000_007F);
    run(20);
    wr(1'b0, 32'h0000_005F);
    // R9 R6: duty above period while running, taken at wrap -> constant active
    cur_tag = "R9";
    run(2);
    wr(1'b1, 32'h0005_0007);
    run(20);
    cur_tag = "R6";
    wr(1'b1, 32'h0005_0000);
    run(15);
    // R9: shadow update mid-period with a longer period
    cur_tag = "R9";
    wr(1'b1, 32'h0008_0004);
    run(12);
    wr(1'b1, 32'h0002_0001);
    run(20);
    // R5: gate low freezes the waveform, then resumes
    cur_tag = "R5";
    wr(1'b1, 32'h0006_0003);
    run(8);
    wr(1'b0, 32'h0000_001F);
    run(20);
    wr(1'b0, 32'h0000_005F);
    run(10);
    // R3: ratio 120 (code 0), gate dropped before code change
    cur_tag = "R3";
    wr(1'b0, 32'h0000_001F);
    wr(1'b0, 32'h0000_0010);
    wr(1'b0, 32'h0000_0050);
    wr(1'b1, 32'h0003_0001);
    run(800);
    // R3: ratio 180 (code 1)
    wr(1'b0, 32'h0000_0000);
    wr(1'b0, 32'h0000_0051);
    run(1200);
    // R4: reserved code 5 holds count
    cur_tag = "R4";
    wr(1'b0, 32'h0000_0015);
    wr(1'b0, 32'h0000_005F);
    run(4);
    wr(1'b0, 32'h0000_0015);
    wr(1'b0, 32'h0000_0055);
    run(20);
    wr(1'b0, 32'h0000_005D);
    run(20);
    // R8: disable with invert -> idle high, then low
    cur_tag = "R8";
    wr(1'b0, 32'h0000_0020);
    run(6);
    wr(1'b0, 32'h0000_0000);
    run(6);
    // R10: full 16-bit counts
    cur_tag = "R10";
    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b0, 32'h0000_005F);
    run(300);
    wr(1'b1, 32'hFFFF_0000);
    run(10);
    rd_check(1'b1, 32'hFFFF_0000, "R10");
    wr(1'b0, 32'h0);
    run(4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule